// File: doc/BRIEF.md
# Multiplexed-Address DRAM Access Controller

This block connects a simple host request port to a DRAM device whose row and column addresses share one set of address pins. For each host request it opens the addressed row with the row strobe and then issues one or more column cycles under the column strobe. During a burst the column advances by one on every beat, so a whole block moves while the row stays open. The row is closed again after every transaction. Reads assert the output-enable line and writes assert the write-enable line. Data in both directions travels on one shared bidirectional data bus.

A refresh scheduler raises a request at a fixed interval. The row under refresh is given by a counter that steps through every row in turn. A refresh opens that row with the column strobe held inactive, which makes the device read the row and write it back. A refresh that falls due while a transaction is running waits until the row has been closed. The host is then held off until the refresh has completed. All delays are parameters counted in clock cycles.

Top module: `mux_dram_ctrl`

## Requirements
- R1: The host address is split into a row field (upper ROW_W bits) driven on `dram_addr` while the row strobe first goes low, and a column field (lower COL_W bits) driven on the first column cycle.
- R2: Every transaction opens its row with `dram_ras_n` low and `dram_cas_n` high for exactly T_RCD cycles before the first column cycle.
- R3: A transaction makes `host_blen`+1 column cycles back to back (`dram_cas_n` low). The column on `dram_addr` rises by one per beat, and the row stays open with no second activation.
- R4: On read column cycles `dram_oe_n` is low and `dram_we_n` high. On write column cycles `dram_we_n` is low, `dram_dq` carries `host_wdata` and `host_wtake` is high. The two enables are never low together.
- R5: Read data on `dram_dq` is sampled T_CL cycles after its column cycle and presented with `host_rvalid` high for one cycle per beat, in column order. No extra valid beats appear.
- R6: Data written by a burst is returned unchanged by a later read of the same locations.
- R7: A burst that passes the last column of a row wraps to column 0 of the same row.
- R8: A refresh holds `dram_ras_n` low with `dram_cas_n` high for exactly T_RFC cycles and drives the refresh row on `dram_addr`. The first refresh uses row 0, and each later one uses the next row, wrapping after the last.
- R9: A refresh falls due every T_REFI cycles. It is never started inside a transaction. It is taken before any waiting host request, so the n-th refresh begins within n*T_REFI plus a small fixed slack, and every row is refreshed within 2^ROW_W refresh intervals.
- R10: After each transaction or refresh the row strobe stays high for at least T_RP+1 cycles before the next activation.
- R11: `host_ready` is high only while the controller is idle with no refresh pending, and a request is taken on a cycle with `host_req` and `host_ready` both high. After reset `host_ready` is high, all four strobes are high and `host_rvalid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host request valid |
| host_ready | output | 1 | Controller can accept a request |
| host_addr | input | ROW_W+COL_W | Row field in upper bits, column field in lower bits |
| host_we | input | 1 | 1 = write burst, 0 = read burst |
| host_blen | input | BLEN_W | Number of beats minus one |
| host_wdata | input | DATA_W | Write data for the current beat |
| host_wtake | output | 1 | Current write beat is taken at the next edge |
| host_rdata | output | DATA_W | Read data |
| host_rvalid | output | 1 | `host_rdata` holds one read beat |
| dram_addr | output | max(ROW_W,COL_W) | Shared row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq | inout | DATA_W | Bidirectional data bus |

## Verification
Some properties are checked on every cycle. Column cycles follow each other with a column that rises by one. A pending refresh stays pending until it is serviced. The refresh row steps by one per refresh. A column cycle is never followed directly by a refresh, and an accepted request always leads to a row activation. Other behaviours can only be shown by the bench scenarios. These are the address split, the exact activation and refresh lengths, and read data matching earlier writes, including bursts that wrap at the row end. The scenarios also show that refreshes stay on schedule under heavy back-to-back traffic and that every row is covered across a full refresh sweep.

// File: rtl/mdc_pkg.sv
package mdc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ACT   = 3'd1,
    ST_COL   = 3'd2,
    ST_DRAIN = 3'd3,
    ST_PRE   = 3'd4,
    ST_REF   = 3'd5
  } ctl_state_t;
endpackage

// File: rtl/mdc_refresh_sched.sv
module mdc_refresh_sched #(
  parameter int ROW_W  = 11,
  parameter int T_REFI = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack,
  output logic             pend,
  output logic [ROW_W-1:0] row
);
  localparam int CW = (T_REFI > 2) ? $clog2(T_REFI) : 1;

  logic [CW-1:0]    tick_q, tick_d;
  logic             pend_d;
  logic [ROW_W-1:0] row_d;
  logic             tick;

  always_comb begin
    tick   = (tick_q == CW'(T_REFI - 1));
    tick_d = tick ? '0 : tick_q + 1'b1;
    pend_d = (pend & ~ack) | tick;
    row_d  = ack ? row + 1'b1 : row;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      pend   <= 1'b0;
      row    <= '0;
    end else begin
      tick_q <= tick_d;
      pend   <= pend_d;
      row    <= row_d;
    end
  end

  AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !ack) |=> pend); // R9
  AST_REF_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (row == ROW_W'($past(row) + 1'b1))); // R8
endmodule

// File: rtl/mdc_col_gen.sv
module mdc_col_gen #(
  parameter int COL_W  = 11,
  parameter int BLEN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [COL_W-1:0]  col_in,
  input  logic [BLEN_W-1:0] beats_in,
  input  logic              step,
  output logic [COL_W-1:0]  col,
  output logic              last
);
  logic [BLEN_W-1:0] left_q;
  logic [COL_W-1:0]  col_d;
  logic [BLEN_W-1:0] left_d;
  logic              en;

  always_comb begin
    en     = load | step;
    col_d  = load ? col_in   : col + 1'b1;
    left_d = load ? beats_in : left_q - 1'b1;
    last   = (left_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col    <= '0;
      left_q <= '0;
    end else if (en) begin
      col    <= col_d;
      left_q <= left_d;
    end
  end
endmodule

// File: rtl/mux_dram_ctrl.sv
module mux_dram_ctrl
  import mdc_pkg::*;
#(
  parameter int ROW_W  = 11,
  parameter int COL_W  = 11,
  parameter int DATA_W = 16,
  parameter int BLEN_W = 4,
  parameter int T_RCD  = 2,
  parameter int T_CL   = 2,
  parameter int T_RP   = 1,
  parameter int T_RFC  = 4,
  parameter int T_REFI = 32,
  localparam int AW    = ROW_W + COL_W,
  localparam int PW    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  output logic              host_ready,
  input  logic [AW-1:0]     host_addr,
  input  logic              host_we,
  input  logic [BLEN_W-1:0] host_blen,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_wtake,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic [PW-1:0]     dram_addr,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  inout  wire  [DATA_W-1:0] dram_dq
);
  localparam int T1   = (T_RCD > T_RFC) ? T_RCD : T_RFC;
  localparam int T2   = (T_CL > T_RP) ? T_CL : T_RP;
  localparam int TMAX = (T1 > T2) ? T1 : T2;
  localparam int DW   = $clog2(TMAX + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  ctl_state_t       state_q, state_d;
  logic [DW-1:0]    dly_q, dly_d;
  logic [ROW_W-1:0] row_q;
  logic             we_q;
  logic [T_CL-1:0]  rd_pipe_q;
  logic             accept, ref_ack, ref_pend, col_step, col_last, rd_issue;
  logic [ROW_W-1:0] ref_row;
  logic [COL_W-1:0] col;

  mdc_refresh_sched #(.ROW_W(ROW_W), .T_REFI(T_REFI)) u_ref (
    .clk(clk), .rst_n(rst_i), .ack(ref_ack), .pend(ref_pend), .row(ref_row)
  );

  mdc_col_gen #(.COL_W(COL_W), .BLEN_W(BLEN_W)) u_col (
    .clk(clk), .rst_n(rst_i), .load(accept), .col_in(host_addr[COL_W-1:0]),
    .beats_in(host_blen), .step(col_step), .col(col), .last(col_last)
  );

  assign host_ready = (state_q == ST_IDLE) && !ref_pend;

  always_comb begin
    state_d  = state_q;
    dly_d    = (dly_q != '0) ? dly_q - 1'b1 : dly_q;
    accept   = 1'b0;
    ref_ack  = 1'b0;
    col_step = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ref_pend) begin
          state_d = ST_REF;
          dly_d   = DW'(T_RFC - 1);
        end else if (host_req) begin
          accept  = 1'b1;
          state_d = ST_ACT;
          dly_d   = DW'(T_RCD - 1);
        end
      end
      ST_ACT: if (dly_q == '0) state_d = ST_COL;
      ST_COL: begin
        col_step = 1'b1;
        if (col_last) begin
          state_d = we_q ? ST_PRE : ST_DRAIN;
          dly_d   = we_q ? DW'(T_RP - 1) : DW'(T_CL - 1);
        end
      end
      ST_DRAIN: if (dly_q == '0) begin
        state_d = ST_PRE;
        dly_d   = DW'(T_RP - 1);
      end
      ST_PRE: if (dly_q == '0) state_d = ST_IDLE;
      ST_REF: if (dly_q == '0) begin
        ref_ack = 1'b1;
        state_d = ST_PRE;
        dly_d   = DW'(T_RP - 1);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q     <= ST_IDLE;
      dly_q       <= '0;
      rd_pipe_q   <= '0;
      host_rvalid <= 1'b0;
    end else begin
      state_q     <= state_d;
      dly_q       <= dly_d;
      rd_pipe_q   <= (rd_pipe_q << 1) | T_CL'(rd_issue);
      host_rvalid <= rd_pipe_q[T_CL-1];
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      row_q <= host_addr[AW-1:COL_W];
      we_q  <= host_we;
    end
    if (rd_pipe_q[T_CL-1]) host_rdata <= dram_dq;
  end

  always_comb begin
    rd_issue   = (state_q == ST_COL) && !we_q;
    host_wtake = (state_q == ST_COL) && we_q;
    dram_ras_n = !(state_q inside {ST_ACT, ST_COL, ST_DRAIN, ST_REF});
    dram_cas_n = (state_q != ST_COL);
    dram_we_n  = !host_wtake;
    dram_oe_n  = !rd_issue;
    if (state_q == ST_COL)      dram_addr = PW'(col);
    else if (state_q == ST_REF) dram_addr = PW'(ref_row);
    else                        dram_addr = PW'(row_q);
  end

  assign dram_dq = host_wtake ? host_wdata : {DATA_W{1'bz}};

  AST_ACT_FIRST: assert property (@(posedge clk) disable iff (!rst_i)
    (host_req && host_ready) |=> (!dram_ras_n && dram_cas_n)); // R2
  AST_COL_INC: assert property (@(posedge clk) disable iff (!rst_i)
    (!dram_cas_n && !$past(dram_cas_n)) |-> (dram_addr[COL_W-1:0] == COL_W'($past(dram_addr[COL_W-1:0]) + 1'b1))); // R3
  AST_NO_REF_MIDBURST: assert property (@(posedge clk) disable iff (!rst_i)
    (state_q == ST_COL) |=> (state_q != ST_REF)); // R9
endmodule

// File: tb/mux_dram_ctrl_tb_top.sv
module mux_dram_ctrl_tb_top;
  localparam int ROW_W = 11, COL_W = 11, DATA_W = 16, BLEN_W = 4;
  localparam int T_RCD = 2, T_CL = 2, T_RP = 1, T_RFC = 4, T_REFI = 32;
  localparam int ROWS = 1 << ROW_W, COLS = 1 << COL_W, SLACK = 60;

  logic clk, rst_n, host_req, host_we, host_ready, host_wtake, host_rvalid;
  logic [ROW_W+COL_W-1:0] host_addr;
  logic [BLEN_W-1:0] host_blen;
  logic [DATA_W-1:0] host_wdata, host_rdata;
  logic [10:0] dram_addr;
  logic dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n;
  wire  [DATA_W-1:0] dram_dq;

  mux_dram_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .BLEN_W(BLEN_W),
    .T_RCD(T_RCD), .T_CL(T_CL), .T_RP(T_RP), .T_RFC(T_RFC), .T_REFI(T_REFI)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_ready(host_ready),
    .host_addr(host_addr), .host_we(host_we), .host_blen(host_blen),
    .host_wdata(host_wdata), .host_wtake(host_wtake), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_dq(dram_dq));

  int total = 0, bad = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // behavioural device
  logic [DATA_W-1:0] dmem [int];
  logic [ROW_W-1:0]  m_row;
  logic              m_prev_ras = 1'b1;
  logic              rp_v0 = 1'b0, rp_v1 = 1'b0;
  logic [DATA_W-1:0] rp_d0, rp_d1;
  assign dram_dq = rp_v1 ? rp_d1 : {DATA_W{1'bz}};

  always @(posedge clk) begin
    int key;
    key = int'(m_row) * COLS + int'(dram_addr);
    m_prev_ras <= dram_ras_n;
    if (!dram_ras_n && m_prev_ras) m_row <= dram_addr;
    rp_v0 <= !dram_cas_n && !dram_oe_n;
    rp_d0 <= dmem.exists(key) ? dmem[key] : '0;
    rp_v1 <= rp_v0;
    rp_d1 <= rp_d0;
    if (!dram_cas_n && !dram_we_n) dmem[key] = dram_dq;
  end

  // reference state
  logic [DATA_W-1:0] ref_mem [int];
  logic [DATA_W-1:0] exp_q [$];
  int exp_row, exp_col, exp_beats;
  bit exp_we, mon_on = 1'b0;
  int cyc = 0, act_cyc = 0, rise_cyc = -100, ncas = 0, prev_col = 0;
  int ref_cnt = 0, exp_ref_row = 0, done_cnt = 0, act_row = 0;
  bit prev_ras = 1'b1, prev_cas = 1'b1, saw_cas = 1'b0, cas_ended = 1'b0;
  bit seen [ROWS];

  always @(negedge clk) begin
    if (mon_on) begin
      cyc++;
      if (host_ready) chk(dram_ras_n && dram_cas_n, "R11", "ready while busy", 0, 1);
      if (host_rvalid) begin
        if (exp_q.size() == 0) chk(1'b0, "R5", "unexpected rvalid", 1, 0);
        else begin
          logic [DATA_W-1:0] e;
          e = exp_q.pop_front();
          chk(host_rdata == e, "R5", "read data", host_rdata, e);
        end
      end
      if (!dram_ras_n && prev_ras) begin
        chk(cyc - rise_cyc >= T_RP + 1, "R10", "row closed gap", cyc - rise_cyc, T_RP + 1);
        act_cyc = cyc; act_row = int'(dram_addr);
        saw_cas = 1'b0; cas_ended = 1'b0; ncas = 0;
      end
      if (!dram_cas_n) begin
        chk(!cas_ended, "R3", "beats contiguous", 0, 1);
        chk(!(dram_we_n == 1'b0 && dram_oe_n == 1'b0), "R4", "enables exclusive", 1, 0);
        chk(dram_we_n == !exp_we && dram_oe_n == exp_we, "R4", "direction enable",
            {dram_we_n, dram_oe_n}, {!exp_we, exp_we});
        if (exp_we) chk(dram_dq == host_wdata && host_wtake, "R4", "write drive", dram_dq, host_wdata);
        if (!saw_cas) begin
          chk(act_row == exp_row, "R1", "row field", act_row, exp_row);
          chk(int'(dram_addr) == exp_col, "R1", "column field", dram_addr, exp_col);
          chk(cyc - act_cyc == T_RCD, "R2", "activate length", cyc - act_cyc, T_RCD);
        end else if (prev_col == COLS - 1)
          chk(int'(dram_addr) == 0, "R7", "column wrap", dram_addr, 0);
        else
          chk(int'(dram_addr) == prev_col + 1, "R3", "column step", dram_addr, prev_col + 1);
        prev_col = int'(dram_addr); saw_cas = 1'b1; ncas++;
      end else if (saw_cas) cas_ended = 1'b1;
      if (dram_ras_n && !prev_ras) begin
        rise_cyc = cyc;
        if (saw_cas) begin
          chk(ncas == exp_beats, "R3", "beat count", ncas, exp_beats);
          done_cnt++;
        end else begin
          ref_cnt++;
          chk(cyc - act_cyc == T_RFC, "R8", "refresh length", cyc - act_cyc, T_RFC);
          chk(act_row == exp_ref_row, "R8", "refresh row", act_row, exp_ref_row);
          chk(act_cyc <= ref_cnt * T_REFI + SLACK, "R9", "refresh schedule",
              act_cyc, ref_cnt * T_REFI + SLACK);
          seen[act_row] = 1'b1;
          exp_ref_row = (exp_ref_row + 1) % ROWS;
        end
      end
      prev_ras = dram_ras_n; prev_cas = dram_cas_n;
    end
  end

  task automatic run_txn(input int row, input int col, input int n, input bit we, input int base);
    logic [DATA_W-1:0] w [$];
    int start, idx;
    bit adv;
    for (int i = 0; i < n; i++) begin
      int key;
      key = row * COLS + (col + i) % COLS;
      if (we) begin
        w.push_back(DATA_W'(base * 37 + i * 11 + 5));
        ref_mem[key] = w[i];
      end else exp_q.push_back(ref_mem.exists(key) ? ref_mem[key] : '0);
    end
    @(negedge clk);
    exp_row = row; exp_col = col; exp_beats = n; exp_we = we;
    start = done_cnt;
    host_addr = {ROW_W'(row), COL_W'(col)};
    host_we = we; host_blen = BLEN_W'(n - 1);
    host_wdata = we ? w[0] : '0;
    host_req = 1'b1;
    while (!host_ready) @(negedge clk);
    @(negedge clk);
    host_req = 1'b0;
    idx = 0; adv = 1'b0;
    while (done_cnt == start) begin
      if (adv) begin
        idx++;
        if (we && idx < n) host_wdata = w[idx];
      end
      adv = host_wtake;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic run_all();
    rst_n = 1'b0; host_req = 1'b0; host_we = 1'b0; host_addr = '0;
    host_blen = '0; host_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(host_ready === 1'b1, "R11", "ready after reset", host_ready, 1);
    chk({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n} === 4'hf, "R11", "strobes after reset",
        {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 4'hf);
    chk(host_rvalid === 1'b0, "R11", "rvalid after reset", host_rvalid, 0);
    run_txn(5, 10, 4, 1'b1, 1);        // R6 write burst
    run_txn(5, 10, 4, 1'b0, 0);        // R5 R6 readback
    run_txn(2047, 0, 1, 1'b1, 2);      // single beat, top row
    run_txn(2047, 0, 1, 1'b0, 0);
    run_txn(7, 2046, 4, 1'b1, 3);      // R7 wrap
    run_txn(7, 2046, 4, 1'b0, 0);
    run_txn(300, 100, 16, 1'b1, 4);    // longest burst
    run_txn(300, 100, 16, 1'b0, 0);
    for (int k = 0; k < 24; k++) begin // R9 traffic against refresh
      run_txn(400 + k, 8 * k, 16, 1'b1, 10 + k);
      run_txn(400 + k, 8 * k, 16, 1'b0, 0);
    end
    while (ref_cnt < ROWS + 1) @(negedge clk);
    begin
      int cnt = 0;
      for (int r = 0; r < ROWS; r++) if (seen[r]) cnt++;
      chk(cnt == ROWS, "R9", "all rows refreshed", cnt, ROWS);
    end
    chk(exp_q.size() == 0, "R5", "all read beats returned", exp_q.size(), 0);
  endtask

  initial begin
    bit wd = 1'b0;
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    disable fork;
    if (wd) chk(1'b0, "R9", "watchdog expired", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule